// File: doc/BRIEF.md
# GF(2) Matrix Rank Classifier

This block takes a serial stream of bits that are supposed to be random and cuts it into consecutive N x N binary matrices, with N = 32 by default. It finds the rank of each matrix over GF(2) by Gaussian elimination in hardware. Each matrix is then placed in one of three bins: full rank, rank one below full, or any lower rank. Software starts a run with a pulse that also loads the number of matrices to examine. When that many matrices have been classified, the block raises a one-cycle completion pulse and holds the three bin counts until the next run starts. The chi-square statistic and the P-value are computed off-chip from the counts. The package provides the expected bin probabilities as fixed Q0.16 constants for that comparison.

Bits arrive with a valid strobe and are taken on every clock edge where the ready output is high. The block drops ready while it eliminates, so the source stalls and no bits are lost.

The controller has six states:
- IDLE: waits for start. Any bits offered here are accepted and thrown away.
- FILL: collects bits into the matrix.
- PIVOT: searches one column for a pivot row.
- REDUCE: swaps the pivot row into place and clears the column from every other row.
- CLASSIFY: bins the finished rank.
- FINISH: drives the done pulse.

The transitions are:
- start → FILL, or → FINISH when zero matrices are requested. This applies from any state.
- FILL → PIVOT on the last bit of a matrix.
- PIVOT → REDUCE, always.
- REDUCE → PIVOT for the next column.
- REDUCE → CLASSIFY after the last column.
- CLASSIFY → FILL when more matrices remain.
- CLASSIFY → FINISH after the last matrix.
- FINISH → IDLE, always.

Top module: `gf2_rank_engine`

## Requirements
- R1: After reset all three counts are zero and done is low.
- R2: Accepted bits fill a matrix in row order, row 0 first. Within a row the bits go to column 0 first, then column 1, and so on. N*N consecutive accepted bits make exactly one matrix.
- R3: A matrix whose GF(2) rank equals N increments cnt_full.
- R4: A matrix whose GF(2) rank equals N-1 increments cnt_minus1.
- R5: A matrix with any lower rank increments cnt_low, so the three counts add up to the number of matrices classified (while none has saturated).
- R6: bit_ready is low at the clock edge that accepts the final bit of a matrix. It stays low until that matrix has been classified.
- R7: done is high for exactly one cycle. It rises at the 2N+1-th rising edge after the edge that accepted the final bit of the last matrix. The counts already include that matrix at that point and hold their values until the next start.
- R8: Each count saturates at 2^CNT_W-1 and does not wrap.
- R9: A start pulse does four things. It clears the counts, discards any partly filled matrix and latches num_mats. It also holds bit_ready low in its own cycle.
- R10: Bits offered in IDLE after done are accepted and discarded: the counts do not change and done stays low.
- R11: A start with num_mats = 0 gives done at the next rising edge, with all counts at zero.
- R12: The package gives the expected bin probabilities in Q0.16 as follows: full 18927, one-below-full 37854, lower 8756.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run, clears the counts, latches num_mats |
| num_mats | input | MAT_W | Number of matrices to classify in this run |
| bit_valid | input | 1 | bit_in holds a stream bit |
| bit_in | input | 1 | Serial stream bit |
| bit_ready | output | 1 | A bit is taken at each edge where bit_valid and bit_ready are both high |
| done | output | 1 | One-cycle pulse when the run completes |
| cnt_full | output | CNT_W | Matrices of rank N |
| cnt_minus1 | output | CNT_W | Matrices of rank N-1 |
| cnt_low | output | CNT_W | Matrices of rank below N-1 |

## Verification
Two functions can fall on the same clock edge.

The first pair is the bin update for the final matrix and the entry into FINISH. The counts seen with done must already include that matrix. The bench checks this with runs whose last matrix lands in each bin. The scoreboard compares the counts in the exact cycle done is high, and the bench also checks the number of cycles from the final bit to done.

The second pair is a start arriving while a matrix is half filled. The bench abandons a matrix of 300 zero bits by restarting, then sends a full-rank matrix. A single full-rank count shows that the stale bits were dropped. A low bit_ready in the start cycle shows that no bit was taken in that cycle.

// File: rtl/rank_pkg.sv
package rank_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FILL,
        S_PIVOT,
        S_REDUCE,
        S_CLASSIFY,
        S_FINISH
    } rank_state_t;

    localparam int unsigned NUM_BINS = 3;
    localparam int unsigned BIN_FULL   = 0;
    localparam int unsigned BIN_MINUS1 = 1;
    localparam int unsigned BIN_LOW    = 2;

    // Expected bin probabilities for 32x32 matrices, Q0.16 (R12)
    localparam logic [15:0] PROB_FULL_Q16   = 16'd18927;
    localparam logic [15:0] PROB_MINUS1_Q16 = 16'd37854;
    localparam logic [15:0] PROB_LOW_Q16    = 16'd8756;

endpackage

// File: rtl/gf2_pivot_find.sv
module gf2_pivot_find #(
    parameter int N      = 32,
    parameter int IDX_W  = $clog2(N),
    parameter int RANK_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      col_bits,
    input  logic [RANK_W-1:0] min_row,
    output logic              found,
    output logic [IDX_W-1:0]  idx
);
    // Lowest row at or below min_row with a one in the column under test
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (col_bits[i] && (i >= int'(min_row))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/gf2_row_reduce.sv
module gf2_row_reduce #(
    parameter int N     = 32,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0][N-1:0] rows_in,
    input  logic [IDX_W-1:0]    col,
    input  logic [IDX_W-1:0]    pivot,
    input  logic [IDX_W-1:0]    target,
    output logic [N-1:0][N-1:0] rows_out
);
    logic [N-1:0] prow;
    assign prow = rows_in[pivot];

    // Swap pivot into target slot, then clear the column in every other row
    for (genvar i = 0; i < N; i++) begin : g_row
        logic [N-1:0] src;
        assign src = (IDX_W'(i) == target) ? rows_in[pivot] :
                     (IDX_W'(i) == pivot)  ? rows_in[target] : rows_in[i];
        assign rows_out[i] = ((IDX_W'(i) != target) && src[col]) ? (src ^ prow) : src;
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] value
);
    localparam logic [W-1:0] MAX = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     value <= '0;
        else if (clear)                 value <= '0;
        else if (inc && value != MAX)   value <= value + W'(1);
    end
endmodule

// File: rtl/gf2_rank_engine.sv
module gf2_rank_engine
    import rank_pkg::*;
#(
    parameter int N     = 32,
    parameter int CNT_W = 16,
    parameter int MAT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [MAT_W-1:0] num_mats,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic             bit_ready,
    output logic             done,
    output logic [CNT_W-1:0] cnt_full,
    output logic [CNT_W-1:0] cnt_minus1,
    output logic [CNT_W-1:0] cnt_low
);
    localparam int IDX_W  = $clog2(N);
    localparam int RANK_W = $clog2(N + 1);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    rank_state_t state, nstate;

    logic [N-1:0][N-1:0] mat, mat_red;
    logic [N-1:0]        col_bits;
    logic [IDX_W-1:0]    fill_row, fill_col, col_k, piv_idx, find_idx;
    logic [RANK_W-1:0]   rank_q;
    logic                piv_found, find_ok, accept, last_bit;
    logic [MAT_W-1:0]    target, mat_done;
    logic [NUM_BINS-1:0] bin_hit;
    logic [NUM_BINS-1:0][CNT_W-1:0] cnt_arr;

    assign accept   = bit_valid && bit_ready;
    assign last_bit = (fill_row == LAST) && (fill_col == LAST);

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            S_IDLE:     nstate = S_IDLE;
            S_FILL:     if (accept && last_bit) nstate = S_PIVOT;
            S_PIVOT:    nstate = S_REDUCE;
            S_REDUCE:   nstate = (col_k == LAST) ? S_CLASSIFY : S_PIVOT;
            S_CLASSIFY: nstate = ((mat_done + MAT_W'(1)) == target) ? S_FINISH : S_FILL;
            S_FINISH:   nstate = S_IDLE;
            default:    nstate = S_IDLE;
        endcase
        if (start) nstate = (num_mats == '0) ? S_FINISH : S_FILL;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nstate;
    end

    // Outputs
    always_comb begin
        bit_ready = ((state == S_IDLE) || (state == S_FILL)) && !start;
        done      = (state == S_FINISH);
    end

    // Pivot search on the current column
    always_comb begin
        for (int i = 0; i < N; i++) col_bits[i] = mat[i][col_k];
    end

    gf2_pivot_find #(.N(N), .IDX_W(IDX_W), .RANK_W(RANK_W)) u_find (
        .col_bits (col_bits),
        .min_row  (rank_q),
        .found    (find_ok),
        .idx      (find_idx)
    );

    gf2_row_reduce #(.N(N), .IDX_W(IDX_W)) u_reduce (
        .rows_in  (mat),
        .col      (col_k),
        .pivot    (piv_idx),
        .target   (rank_q[IDX_W-1:0]),
        .rows_out (mat_red)
    );

    // Matrix storage: filled serially, rewritten by elimination
    always_ff @(posedge clk) begin
        if (!start) begin
            if (state == S_FILL && accept)
                mat[fill_row][fill_col] <= bit_in;
            else if (state == S_REDUCE && piv_found)
                mat <= mat_red;
        end
    end

    // Sequencing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_row  <= '0;
            fill_col  <= '0;
            col_k     <= '0;
            rank_q    <= '0;
            piv_idx   <= '0;
            piv_found <= 1'b0;
            mat_done  <= '0;
            target    <= '0;
        end else if (start) begin
            fill_row <= '0;
            fill_col <= '0;
            col_k    <= '0;
            rank_q   <= '0;
            mat_done <= '0;
            target   <= num_mats;
        end else begin
            unique case (state)
                S_FILL: if (accept) begin
                    fill_col <= (fill_col == LAST) ? '0 : fill_col + IDX_W'(1);
                    if (fill_col == LAST)
                        fill_row <= (fill_row == LAST) ? '0 : fill_row + IDX_W'(1);
                end
                S_PIVOT: begin
                    piv_idx   <= find_idx;
                    piv_found <= find_ok;
                end
                S_REDUCE: begin
                    if (piv_found) rank_q <= rank_q + RANK_W'(1);
                    col_k <= (col_k == LAST) ? '0 : col_k + IDX_W'(1);
                end
                S_CLASSIFY: begin
                    rank_q   <= '0;
                    col_k    <= '0;
                    mat_done <= mat_done + MAT_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Rank binning and saturating counters
    assign bin_hit[BIN_FULL]   = (rank_q == RANK_W'(N));
    assign bin_hit[BIN_MINUS1] = (rank_q == RANK_W'(N - 1));
    assign bin_hit[BIN_LOW]    = !bin_hit[BIN_FULL] && !bin_hit[BIN_MINUS1];

    for (genvar g = 0; g < NUM_BINS; g++) begin : g_bin
        sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (start),
            .inc   ((state == S_CLASSIFY) && bin_hit[g]),
            .value (cnt_arr[g])
        );
    end

    assign cnt_full   = cnt_arr[BIN_FULL];
    assign cnt_minus1 = cnt_arr[BIN_MINUS1];
    assign cnt_low    = cnt_arr[BIN_LOW];

endmodule

// File: rtl/rank_engine_checker.sv
module rank_engine_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             bit_ready,
    input logic             done,
    input logic [CNT_W-1:0] cnt_full,
    input logic [CNT_W-1:0] cnt_minus1,
    input logic [CNT_W-1:0] cnt_low
);
    localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

    logic [CNT_W+1:0] total;
    assign total = (CNT_W+2)'(cnt_full) + (CNT_W+2)'(cnt_minus1) + (CNT_W+2)'(cnt_low);

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_stall_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !bit_ready);

    p_clear_on_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_full == '0) && (cnt_minus1 == '0) && (cnt_low == '0));

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_full == MAXV) |=> (cnt_full == MAXV));

    p_monotone_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt_low >= $past(cnt_low)) && (cnt_minus1 >= $past(cnt_minus1)));

    p_one_bin_per_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (total <= $past(total) + (CNT_W+2)'(1)));

endmodule

bind gf2_rank_engine rank_engine_checker #(.CNT_W(CNT_W)) u_rank_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .bit_ready  (bit_ready),
    .done       (done),
    .cnt_full   (cnt_full),
    .cnt_minus1 (cnt_minus1),
    .cnt_low    (cnt_low)
);

// File: tb/tb_gf2_rank_engine.sv
module tb_gf2_rank_engine;
    import rank_pkg::*;

    localparam int N     = 32;
    localparam int CNT_W = 3;
    localparam int MAT_W = 8;
    localparam int SATV  = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [MAT_W-1:0] num_mats = '0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic bit_ready, done;
    logic [CNT_W-1:0] cnt_full, cnt_minus1, cnt_low;

    always #10 clk = ~clk;

    gf2_rank_engine #(.N(N), .CNT_W(CNT_W), .MAT_W(MAT_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .num_mats(num_mats),
        .bit_valid(bit_valid), .bit_in(bit_in), .bit_ready(bit_ready),
        .done(done), .cnt_full(cnt_full), .cnt_minus1(cnt_minus1), .cnt_low(cnt_low)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct { int full; int m1; int low; } exp_t;
    exp_t sbq[$];

    logic [N-1:0] store [16*N];
    logic [N-1:0] cur [N];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat(input int v);
        return (v > SATV) ? SATV : v;
    endfunction

    // Independent rank: insert rows into a basis keyed by leading bit
    function automatic int cur_rank();
        logic [N-1:0] basis [N];
        int r = 0;
        for (int i = 0; i < N; i++) basis[i] = '0;
        for (int i = 0; i < N; i++) begin
            logic [N-1:0] v;
            v = cur[i];
            for (int b = N - 1; b >= 0; b--) begin
                if (v[b]) begin
                    if (basis[b] == '0) begin
                        basis[b] = v;
                        r++;
                        break;
                    end
                    v ^= basis[b];
                end
            end
        end
        return r;
    endfunction

    task automatic load(input int k);
        for (int r = 0; r < N; r++) cur[r] = store[k*N + r];
    endtask

    // kind: 0 identity, 1 identity with row 5 cleared, 2 zeros, 3 ones,
    //       4 identity with row 7 copied from row 3, 5 upper triangle, 6 random
    task automatic make(input int k, input int kind);
        for (int r = 0; r < N; r++) begin
            logic [N-1:0] row;
            row = '0;
            case (kind)
                0: row[r] = 1'b1;
                1: if (r != 5) row[r] = 1'b1;
                2: row = '0;
                3: row = '1;
                4: row[(r == 7) ? 3 : r] = 1'b1;
                5: for (int c = r; c < N; c++) row[c] = 1'b1;
                default: row = N'($urandom);
            endcase
            store[k*N + r] = row;
        end
    endtask

    task automatic push_expected(input int count);
        exp_t e;
        e.full = 0; e.m1 = 0; e.low = 0;
        for (int k = 0; k < count; k++) begin
            int rk;
            load(k);
            rk = cur_rank();
            if (rk == N) e.full++;
            else if (rk == N - 1) e.m1++;
            else e.low++;
        end
        e.full = sat(e.full); e.m1 = sat(e.m1); e.low = sat(e.low);
        sbq.push_back(e);
    endtask

    task automatic send_bit(input logic b);
        while (!bit_ready) @(negedge clk);
        bit_in = b;
        bit_valid = 1'b1;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    // R2: row 0 first, column 0 first within each row
    task automatic send_matrix(input int k);
        load(k);
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                send_bit(cur[r][c]);
        check(bit_ready == 1'b0, "R6 ready low after final bit", int'(bit_ready), 0);
    endtask

    task automatic pulse_start(input int n);
        @(negedge clk);
        start = 1'b1;
        num_mats = MAT_W'(n);
        #1;
        check(bit_ready == 1'b0, "R9 ready low in start cycle", int'(bit_ready), 0);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done_timed();
        int cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!done && cyc < 500);
        check(cyc == 2*N + 1, "R7 latency final bit to done", cyc, 2*N + 1);
    endtask

    task automatic run(input int count);
        push_expected(count);
        pulse_start(count);
        for (int k = 0; k < count; k++) send_matrix(k);
        wait_done_timed();
        @(negedge clk);
        check(done == 1'b0, "R7 done single cycle", int'(done), 0);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    check(int'(cnt_full) == e.full, "R3 full count", int'(cnt_full), e.full);
                    check(int'(cnt_minus1) == e.m1, "R4 minus-one count", int'(cnt_minus1), e.m1);
                    check(int'(cnt_low) == e.low, "R5 low count", int'(cnt_low), e.low);
                end
            end
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        int hf, hm, hl;
        bit saw_done;
        real chi, p, e1, e2, e3, nm;

        repeat (5) @(negedge clk);
        check(cnt_full == '0 && cnt_minus1 == '0 && cnt_low == '0, "R1 counts zero at reset",
              int'(cnt_full) + int'(cnt_minus1) + int'(cnt_low), 0);
        check(done == 1'b0, "R1 done low at reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);

        check(PROB_FULL_Q16 == 16'd18927, "R12 full constant", int'(PROB_FULL_Q16), 18927);
        check(PROB_MINUS1_Q16 == 16'd37854, "R12 minus-one constant", int'(PROB_MINUS1_Q16), 37854);
        check(PROB_LOW_Q16 == 16'd8756, "R12 low constant", int'(PROB_LOW_Q16), 8756);

        // Structured matrices: two per bin, last one full rank
        make(0, 1); make(1, 2); make(2, 0); make(3, 3); make(4, 4); make(5, 5);
        run(6);

        // R10: idle bits ignored, counts held
        hf = int'(cnt_full); hm = int'(cnt_minus1); hl = int'(cnt_low);
        saw_done = 1'b0;
        for (int i = 0; i < 40; i++) begin
            send_bit(i[0]);
            if (done) saw_done = 1'b1;
        end
        check(!saw_done, "R10 no done from idle bits", int'(saw_done), 0);
        check(int'(cnt_full) == hf && int'(cnt_minus1) == hm && int'(cnt_low) == hl,
              "R10 counts held in idle", int'(cnt_full) + int'(cnt_minus1) + int'(cnt_low), hf + hm + hl);

        // Random matrices, last one forced to low bin
        for (int k = 0; k < 7; k++) make(k, 6);
        make(7, 2);
        run(8);
        nm = 8.0;
        e1 = 0.2888 * nm; e2 = 0.5776 * nm; e3 = 0.1336 * nm;
        chi = (real'(cnt_full) - e1) ** 2 / e1 + (real'(cnt_minus1) - e2) ** 2 / e2
            + (real'(cnt_low) - e3) ** 2 / e3;
        p = $exp(-chi / 2.0);
        $display("chi-square %f  p-value %f", chi, p);

        // R8 saturation, also proves clearing from previous run (R9)
        for (int k = 0; k < 9; k++) make(k, 0);
        run(9);

        // R9: restart abandons a partial matrix
        make(0, 0);
        pulse_start(1);
        for (int i = 0; i < 300; i++) send_bit(1'b0);
        push_expected(1);
        pulse_start(1);
        send_matrix(0);
        wait_done_timed();

        // R11: zero matrices
        begin
            exp_t z;
            z.full = 0; z.m1 = 0; z.low = 0;
            sbq.push_back(z);
        end
        @(negedge clk);
        start = 1'b1;
        num_mats = '0;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R11 done right after zero-length start", int'(done), 1);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R7 every run produced done", sbq.size(), 0);
        summary();
    end
endmodule